// File: doc/BRIEF.md
# Bridge Configuration Cycle Translator

This block sits behind the upstream target logic of a two-port PCI bridge. It decides what happens to a configuration read or write that arrives from the upstream bus. For each presented cycle it takes four inputs: the 4-bit command, the 32-bit address, the bridge's own select line, and the bus number register. From these it places the cycle in one of four classes: claimed by the bridge, converted to a Type 0 cycle on the local secondary bus, forwarded downstream unchanged as Type 1, or dropped.

For converted cycles the block rebuilds the address for the secondary bus. It drives a single upper address line as the device select, for device numbers 0 to 15, and it keeps the function and register fields. It also marks forwarded Type 1 writes as limited to one data phase. The result is registered, so it appears one clock after the request. The bus-signalling state machines and data buffering use this result and are outside the block.

Top module: `cfg_xlate`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `out_kind` is 00 and `out_addr` is zero.
- R2: A request produces `out_valid` = 1 on the next clock only when `in_valid` is high and `in_cmd` is 1010 (configuration read) or 1011 (configuration write). Any other command gives `out_valid` = 0.
- R3: `out_cmd` is the request's command, and the result is registered exactly one cycle after the request.
- R4: A cycle with address bits 1:0 = 00 and `self_sel` high is claimed (`out_kind` = 01), and `out_addr` equals the input address.
- R5: A cycle with address bits 1:0 = 00 and `self_sel` low is dropped (`out_kind` = 00).
- R6: A cycle with address bits 1:0 = 01 (Type 1; bus number in bits 23:16) whose bus number equals the secondary bus number (`bus_cfg` bits 15:8) is converted (`out_kind` = 10).
- R7: In a converted address, bits 1:0 are 00 and bits 15:11 are 0. Bits 10:8 (function) and 7:2 (register) are copied, and for a device number d (input bits 15:11) below 16 only bit 16+d of bits 31:16 is set.
- R8: A converted cycle for device numbers 16 to 31 has address bits 31:11 all zero.
- R9: A Type 1 cycle whose bus number is above the secondary bus number and no greater than the subordinate bus number (`bus_cfg` bits 23:16) is forwarded (`out_kind` = 11) with `out_addr` equal to the input address.
- R10: A cycle is dropped with `out_addr` zero in any of these cases: address bits 1:0 are 10 or 11; it is a Type 1 cycle whose bus number equals the primary bus number (`bus_cfg` bits 7:0); or it is a Type 1 cycle whose bus number is outside the secondary-to-subordinate range. The primary bus number check takes priority over both range matches.
- R11: `out_single` is 1 exactly for forwarded configuration writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded cycle is presented this clock |
| in_cmd | input | 4 | Bus command of the cycle |
| in_addr | input | 32 | Address phase value |
| self_sel | input | 1 | The bridge's own device select is asserted |
| bus_cfg | input | 24 | Primary [7:0], secondary [15:8], subordinate [23:16] bus numbers |
| out_valid | output | 1 | Classification result valid |
| out_kind | output | 2 | 00 drop, 01 claim, 10 convert, 11 forward |
| out_cmd | output | 4 | Command of the classified cycle |
| out_addr | output | 32 | Address to drive downstream, or the claimed address |
| out_single | output | 1 | Forwarded write limited to one data phase |

## Verification
The bench places bus numbers exactly at the secondary number, one above it, at the subordinate number and one past it. At these points an off-by-one comparison would convert a cycle it should forward, or forward one it should drop. It also sends device numbers 0, 15, 16 and 31. A select decoder that wraps or clamps would then set a stray upper address line. Bus numbers equal to the primary number, which are also inside the forwarding range, check the drop priority. Non-configuration commands and the reserved address types 10 and 11 check that a permissive decoder does not emit results it should drop.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    typedef enum logic [1:0] {
        KIND_DROP    = 2'b00,
        KIND_CLAIM   = 2'b01,
        KIND_CONVERT = 2'b10,
        KIND_FORWARD = 2'b11
    } cfg_kind_e;

    localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

    localparam logic [1:0] ADDR_TYPE0 = 2'b00;
    localparam logic [1:0] ADDR_TYPE1 = 2'b01;
endpackage

// File: rtl/cfg_classify.sv
module cfg_classify
    import cfg_xlate_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [3:0]       cmd,
    input  logic [1:0]       addr_type,
    input  logic [BUS_W-1:0] tgt_bus,
    input  logic             self_sel,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output logic             is_cfg,
    output logic             is_write,
    output cfg_kind_e        kind
);
    logic hit_local;
    logic hit_below;
    logic hit_primary;

    always_comb begin
        is_cfg      = (cmd == CMD_CFG_READ) || (cmd == CMD_CFG_WRITE);
        is_write    = (cmd == CMD_CFG_WRITE);
        hit_primary = (tgt_bus == pri_bus);
        hit_local   = (tgt_bus == sec_bus);
        hit_below   = (tgt_bus > sec_bus) && (tgt_bus <= sub_bus);

        kind = KIND_DROP;
        if (addr_type == ADDR_TYPE0) begin
            if (self_sel) begin
                kind = KIND_CLAIM;
            end
        end else if (addr_type == ADDR_TYPE1) begin
            if (hit_primary) begin
                kind = KIND_DROP;
            end else if (hit_local) begin
                kind = KIND_CONVERT;
            end else if (hit_below) begin
                kind = KIND_FORWARD;
            end
        end
    end
endmodule

// File: rtl/cfg_addr_build.sv
module cfg_addr_build
    import cfg_xlate_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SEL_BASE   = 16,
    parameter int SEL_COUNT  = 16,
    parameter int DEV_LSB    = 11,
    parameter int DEV_W      = 5
) (
    input  cfg_kind_e          kind,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic [ADDR_W-1:0]  addr_out
);
    localparam int KEEP_MSB = DEV_LSB - 1;

    logic [DEV_W-1:0]     dev_num;
    logic [SEL_COUNT-1:0] sel_vec;

    assign dev_num = addr_in[DEV_LSB +: DEV_W];

    for (genvar g = 0; g < SEL_COUNT; g++) begin : g_sel
        assign sel_vec[g] = (dev_num == DEV_W'(g));
    end

    always_comb begin
        addr_out = '0;
        unique case (kind)
            KIND_CLAIM, KIND_FORWARD: addr_out = addr_in;
            KIND_CONVERT: begin
                addr_out[KEEP_MSB:2]             = addr_in[KEEP_MSB:2];
                addr_out[SEL_BASE +: SEL_COUNT]  = sel_vec;
            end
            default: addr_out = '0;
        endcase
    end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_W     = 8,
    parameter int SEL_BASE  = 16,
    parameter int SEL_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          in_cmd,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic                self_sel,
    input  logic [3*BUS_W-1:0]  bus_cfg,
    output logic                out_valid,
    output logic [1:0]          out_kind,
    output logic [3:0]          out_cmd,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                out_single
);
    localparam int BUSNUM_LSB = 16;

    typedef struct packed {
        logic              valid;
        cfg_kind_e         kind;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic              single;
    } xl_state_t;

    xl_state_t st_d, st_q;

    logic              cls_is_cfg;
    logic              cls_is_write;
    cfg_kind_e         cls_kind;
    logic [ADDR_W-1:0] built_addr;

    cfg_classify #(.BUS_W(BUS_W)) u_classify (
        .cmd       (in_cmd),
        .addr_type (in_addr[1:0]),
        .tgt_bus   (in_addr[BUSNUM_LSB +: BUS_W]),
        .self_sel  (self_sel),
        .pri_bus   (bus_cfg[0 +: BUS_W]),
        .sec_bus   (bus_cfg[BUS_W +: BUS_W]),
        .sub_bus   (bus_cfg[2*BUS_W +: BUS_W]),
        .is_cfg    (cls_is_cfg),
        .is_write  (cls_is_write),
        .kind      (cls_kind)
    );

    cfg_addr_build #(
        .ADDR_W    (ADDR_W),
        .SEL_BASE  (SEL_BASE),
        .SEL_COUNT (SEL_COUNT)
    ) u_build (
        .kind     (cls_kind),
        .addr_in  (in_addr),
        .addr_out (built_addr)
    );

    always_comb begin
        st_d = '0;
        if (in_valid && cls_is_cfg) begin
            st_d.valid  = 1'b1;
            st_d.kind   = cls_kind;
            st_d.cmd    = in_cmd;
            st_d.addr   = built_addr;
            st_d.single = cls_is_write && (cls_kind == KIND_FORWARD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_kind   = st_q.kind;
    assign out_cmd    = st_q.cmd;
    assign out_addr   = st_q.addr;
    assign out_single = st_q.single;
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_cmd,
    input logic [31:0] in_addr,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic [3:0]  out_cmd,
    input logic [31:0] out_addr,
    input logic        out_single
);
    // R2
    valid_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && ($past(in_cmd[3:1]) == 3'b101)));
    // R3
    cmd_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cmd == $past(in_cmd)));
    // R7
    convert_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b10) |-> ($onehot0(out_addr[31:16]) && out_addr[15:11] == 5'd0 && out_addr[1:0] == 2'b00));
    // R9
    forward_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b11) |-> (out_addr == $past(in_addr)));
    // R10
    drop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 2'b00) |-> (out_addr == 32'd0));
    // R11
    single_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_single |-> (out_valid && out_kind == 2'b11 && out_cmd == 4'b1011));
endmodule

bind cfg_xlate cfg_xlate_chk u_chk (.*);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_cmd = 4'd0;
    logic [31:0] in_addr = 32'd0;
    logic        self_sel = 1'b0;
    logic [23:0] bus_cfg = 24'd0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [3:0]  out_cmd;
    logic [31:0] out_addr;
    logic        out_single;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd),
        .in_addr(in_addr), .self_sel(self_sel), .bus_cfg(bus_cfg),
        .out_valid(out_valid), .out_kind(out_kind), .out_cmd(out_cmd),
        .out_addr(out_addr), .out_single(out_single)
    );

    typedef struct packed {
        logic        v;
        logic [1:0]  k;
        logic [3:0]  c;
        logic [31:0] a;
        logic        s;
    } exp_t;

    function automatic exp_t model(logic vld, logic [3:0] c, logic [31:0] a,
                                   logic sel, logic [23:0] bc);
        exp_t e = '0;
        logic [7:0] bn = a[23:16];
        int dev = int'(a[15:11]);
        if (!(vld && (c == 4'b1010 || c == 4'b1011))) return e;
        e.v = 1'b1;
        e.c = c;
        if (a[1:0] == 2'b00) begin
            if (sel) begin e.k = 2'b01; e.a = a; end
        end else if (a[1:0] == 2'b01) begin
            if (bn == bc[7:0]) e.k = 2'b00;
            else if (bn == bc[15:8]) begin
                e.k = 2'b10;
                e.a[10:2] = a[10:2];
                if (dev < 16) e.a[16 + dev] = 1'b1;
            end else if (bn > bc[15:8] && bn <= bc[23:16]) begin
                e.k = 2'b11; e.a = a; e.s = (c == 4'b1011);
            end
        end
        return e;
    endfunction

    task automatic check(string req, exp_t e);
        exp_t got = {out_valid, out_kind, out_cmd, out_addr, out_single};
        checks++;
        if (got.v != e.v || (e.v && got != e)) begin
            errors++;
            $display("FAIL %s: got v=%0b k=%0b c=%h a=%h s=%0b exp v=%0b k=%0b c=%h a=%h s=%0b",
                     req, got.v, got.k, got.c, got.a, got.s, e.v, e.k, e.c, e.a, e.s);
        end
    endtask

    task automatic apply(string req, logic vld, logic [3:0] c, logic [31:0] a,
                         logic sel, logic [23:0] bc);
        exp_t e;
        @(negedge clk);
        in_valid = vld; in_cmd = c; in_addr = a; self_sel = sel; bus_cfg = bc;
        e = model(vld, c, a, sel, bc);
        @(posedge clk);
        #1;
        check(req, e);
    endtask

    function automatic logic [31:0] t1(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
        return {8'h00, b, d, f, r, 2'b01};
    endfunction

    localparam logic [23:0] BC = {8'h20, 8'h10, 8'h05};

    initial begin
        int unsigned seed = 32'h1234_5678;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_kind !== 2'b00 || out_addr !== 32'd0) begin
            errors++;
            $display("FAIL R1: got v=%0b k=%0b a=%h exp 0 0 0", out_valid, out_kind, out_addr);
        end
        @(negedge clk) rst_n = 1'b1;

        apply("R2 non-cfg cmd", 1'b1, 4'b0110, t1(8'h10, 5'd1, 3'd0, 6'd0), 1'b0, BC);
        apply("R2 valid low", 1'b0, 4'b1010, t1(8'h10, 5'd1, 3'd0, 6'd0), 1'b0, BC);
        apply("R3 R4 claim", 1'b1, 4'b1010, 32'h0000_0a48, 1'b1, BC);
        apply("R5 type0 unselected", 1'b1, 4'b1011, 32'h0000_0a48, 1'b0, BC);
        apply("R6 R7 dev0", 1'b1, 4'b1010, t1(8'h10, 5'd0, 3'd5, 6'h2a), 1'b0, BC);
        apply("R7 dev15", 1'b1, 4'b1011, t1(8'h10, 5'd15, 3'd7, 6'h3f), 1'b0, BC);
        apply("R8 dev16", 1'b1, 4'b1010, t1(8'h10, 5'd16, 3'd1, 6'h01), 1'b0, BC);
        apply("R8 dev31", 1'b1, 4'b1011, t1(8'h10, 5'd31, 3'd2, 6'h10), 1'b0, BC);
        apply("R9 sec+1", 1'b1, 4'b1010, t1(8'h11, 5'd3, 3'd0, 6'h04), 1'b0, BC);
        apply("R9 R11 sub write", 1'b1, 4'b1011, t1(8'h20, 5'd3, 3'd0, 6'h04), 1'b0, BC);
        apply("R10 sub+1", 1'b1, 4'b1011, t1(8'h21, 5'd3, 3'd0, 6'h04), 1'b0, BC);
        apply("R10 below sec", 1'b1, 4'b1010, t1(8'h0f, 5'd3, 3'd0, 6'h04), 1'b0, BC);
        apply("R10 type 10", 1'b1, 4'b1010, 32'h0010_0002, 1'b1, BC);
        apply("R10 type 11", 1'b1, 4'b1011, 32'h0011_0003, 1'b1, BC);
        apply("R10 primary priority", 1'b1, 4'b1011, t1(8'h15, 5'd2, 3'd0, 6'h00), 1'b0,
              {8'h20, 8'h10, 8'h15});
        apply("R11 forwarded read", 1'b1, 4'b1010, t1(8'h18, 5'd9, 3'd3, 6'h07), 1'b0, BC);

        for (int i = 0; i < 2000; i++) begin
            logic [7:0]  sec = 8'($urandom_range(1, 200));
            logic [7:0]  sub = sec + 8'($urandom_range(0, 40));
            logic [7:0]  pri = 8'($urandom_range(0, 255));
            logic [31:0] a = $urandom;
            logic [3:0]  c = ($urandom_range(0, 3) != 0) ? {3'b101, 1'($urandom)} : 4'($urandom);
            if ($urandom_range(0, 2) == 0) a[23:16] = sec;
            else if ($urandom_range(0, 1) == 0) a[23:16] = sec + 8'($urandom_range(0, 42));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b01;
            apply("R2-R11 random", 1'($urandom_range(0, 7) != 0), c, a, 1'($urandom), {sub, sec, pri});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule